// File: doc/BRIEF.md
# Cache Error Capture Register Unit

This unit records what a second-level cache looked like when its controller reported an error. Three kinds of report are handled. A tag or control-store parity error, or an uncorrectable check-code error in a data half, takes a snapshot of the line state, the four per-longword syndromes and a check-code marker. That snapshot is kept in one of two independent 32-bit halves of a 64-bit error register. A correctable check-code error freezes a separate map-index register. Software reads both registers through a simple port. It clears the flag bits by writing ones to them, which re-arms the capture.

Each half runs a two-state machine. In `H_ARMED` it waits for a qualified error. The transition ARMED→FROZEN takes a snapshot and sets the flags. In `H_FROZEN` the snapshot holds. Further errors only set missed bits (FROZEN→FROZEN hold). When software clears the last primary flag, FROZEN→ARMED follows. If a new error arrives in that same cycle, the transition is FROZEN→FROZEN recapture instead.

The correctable-error machine has two states. In `C_TRACK` the register follows every valid map index. The transition TRACK→HELD happens on a qualified correctable error. In `C_HELD` the index holds. HELD→TRACK happens when the flag is cleared. HELD→HELD recapture happens when the flag is cleared and a new correctable error arrives in the same cycle.

Errors are only detected for certain transaction types. The transaction code is a 4-bit input with these values:
- 0: none
- 1: masked write hitting a shared line
- 2: load-locked
- 3: store-conditional
- 4: victim eviction
- 5: system-bus read
- 6: system-bus write as requester
- 7: system-bus write as bystander or responder
- 8: system-bus exchange
- 9 to 15: unused

Top module: `cec_capture_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every flag, snapshot field, index and machine state, so both registers read zero.
- R2: Error register (`reg_sel`=0) layout, with half h at bits 32h and up and SYN_W=8:
  - [7:0] syndrome of slot h
  - [15:8] syndrome of slot h+2
  - [16] check-code marker, set when the capture came from an uncorrectable error
  - [17] valid, [18] dirty, [19] shared, [20] control parity
  - [21] UNC flag, [22] MISSED_UNC, [23] PAR flag, [24] MISSED_PAR

  A qualified uncorrectable error in an armed half captures all snapshot fields and sets UNC. The register shows this one cycle after the error.
- R3: A qualified parity error in an armed half captures the snapshot with the marker at 0 and sets PAR.
- R4: While UNC or PAR of a half is set, and is not being cleared, bits [20:0] of that half do not change.
- R5: A qualified error that arrives while its half is frozen sets MISSED_UNC or MISSED_PAR. The missed bits never block a later capture, and a capture leaves them unchanged.
- R6: Writing to the error register clears each flag bit ([24:21] of a half) whose write-data bit is 1. A 0 leaves the flag unchanged. All other fields ignore writes.
- R7: If a flag clear and a qualified error reach a half in the same cycle, the error wins: the snapshot is retaken and the flags reflect the new error.
- R8: The two halves capture, freeze and clear independently. Each sees only its own error inputs and write bits.
- R9: Parity errors are detected only for transaction codes 1 to 8.
- R10: Check-code errors, both uncorrectable and correctable, are detected for codes 1, 3, 4, 5, 6 and 8, and never for code 2 or code 7.
- R11: Index register (`reg_sel`=1) layout: [16:0] map index, [32] CE flag (write one to clear), [33] pointer-valid. While CE is clear, the index takes `map_idx` on every cycle with `idx_vld`.
- R12: A qualified correctable error on any longword sets CE and captures the index: `map_idx` if `idx_vld`, otherwise the held index. While CE is set the index is frozen. Clearing CE resumes tracking. A clear and a new error in the same cycle recapture.
- R13: Pointer-valid is captured as 1 exactly when the correctable error involves longword 0 or longword 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_kind | input | 4 | Transaction code of the current cycle |
| unc_err | input | 2 | Uncorrectable check-code error per data half |
| par_err | input | 2 | Tag/control parity error per half |
| ce_err | input | 4 | Correctable check-code error per longword slot |
| idx_vld | input | 1 | Map index valid this cycle |
| map_idx | input | IDX_W | Cache map index of the current access |
| ln_valid | input | 1 | Line valid bit |
| ln_dirty | input | 1 | Line dirty bit |
| ln_shared | input | 1 | Line shared bit |
| ln_cpar | input | 1 | Control-bit parity |
| syn_in | input | 4*SYN_W | Syndromes, slot k at bits [k*SYN_W +: SYN_W] |
| reg_sel | input | 1 | 0 selects the error register, 1 the index register |
| reg_wr | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |

## Verification
A half machine stuck in the wrong state shows at the ports one cycle after the next error. A half wrongly armed overwrites its syndromes and line bits. A half wrongly frozen fails to set its flag and sets a missed bit instead. Wrong qualification shows as a flag that appears or stays absent after a single pulsed error. The correctable machine shows its state directly in the index field: a held index that moves, or a tracked index that does not follow `map_idx`, is visible on the next read. For these reasons every check reads back one cycle after a single-cycle stimulus.

// File: rtl/cec_pkg.sv
package cec_pkg;

    localparam logic [3:0] TX_NONE        = 4'd0;
    localparam logic [3:0] TX_MASKWR_SH   = 4'd1;
    localparam logic [3:0] TX_LOCK_LD     = 4'd2;
    localparam logic [3:0] TX_COND_ST     = 4'd3;
    localparam logic [3:0] TX_EVICT       = 4'd4;
    localparam logic [3:0] TX_SB_RD       = 4'd5;
    localparam logic [3:0] TX_SB_WR_OWN   = 4'd6;
    localparam logic [3:0] TX_SB_WR_SNOOP = 4'd7;
    localparam logic [3:0] TX_SB_XCHG     = 4'd8;

    typedef struct packed {
        logic cpar;
        logic shared;
        logic dirty;
        logic valid;
    } line_st_t;

    typedef enum logic {H_ARMED = 1'b0, H_FROZEN = 1'b1} half_st_e;
    typedef enum logic {C_TRACK = 1'b0, C_HELD = 1'b1} ce_st_e;

    function automatic logic par_allowed(input logic [3:0] t);
        return (t >= TX_MASKWR_SH) && (t <= TX_SB_XCHG);
    endfunction

    function automatic logic edc_allowed(input logic [3:0] t);
        return par_allowed(t) && (t != TX_LOCK_LD) && (t != TX_SB_WR_SNOOP);
    endfunction

endpackage

// File: rtl/cec_qual.sv
module cec_qual
    import cec_pkg::*;
#(
    parameter int NHALF = 2,
    parameter int NLW   = 4
) (
    input  logic [3:0]       txn_kind,
    input  logic [NHALF-1:0] unc_err,
    input  logic [NHALF-1:0] par_err,
    input  logic [NLW-1:0]   ce_err,
    output logic [NHALF-1:0] det_unc,
    output logic [NHALF-1:0] det_par,
    output logic             det_ce,
    output logic             ce_ptr
);
    logic edc_ok;
    logic par_ok;

    always_comb begin
        edc_ok = edc_allowed(txn_kind);
        par_ok = par_allowed(txn_kind);
    end

    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            assign det_unc[h] = unc_err[h] & edc_ok;
            assign det_par[h] = par_err[h] & par_ok;
        end
    endgenerate

    assign det_ce = edc_ok & (|ce_err);
    assign ce_ptr = ce_err[0] | ce_err[2];

endmodule

// File: rtl/cec_half.sv
module cec_half
    import cec_pkg::*;
#(
    parameter int SYN_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_unc,
    input  logic              det_par,
    input  line_st_t          line_in,
    input  logic [SYN_W-1:0]  syn_a,
    input  logic [SYN_W-1:0]  syn_b,
    input  logic [3:0]        clr,
    output logic [WORD_W-1:0] word,
    output logic              frozen
);
    localparam int O_EDC  = 2 * SYN_W;
    localparam int O_LINE = O_EDC + 1;
    localparam int O_FLG  = O_LINE + 4;

    half_st_e         state_q, state_d;
    logic             cap_en, set_munc, set_mpar, any_det, prim_keep;
    logic [SYN_W-1:0] syn_a_q, syn_b_q;
    line_st_t         line_q;
    logic             edc_q, unc_q, munc_q, par_q, mpar_q;

    assign any_det   = det_unc | det_par;
    assign prim_keep = (unc_q & ~clr[0]) | (par_q & ~clr[2]);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_ARMED:  if (any_det) state_d = H_FROZEN;
            H_FROZEN: if (!prim_keep && !any_det) state_d = H_ARMED;
            default:  state_d = H_ARMED;
        endcase
    end

    // outputs of the machine
    always_comb begin
        cap_en   = 1'b0;
        set_munc = 1'b0;
        set_mpar = 1'b0;
        unique case (state_q)
            H_ARMED: cap_en = any_det;
            H_FROZEN: begin
                if (prim_keep) begin
                    set_munc = det_unc;
                    set_mpar = det_par;
                end else begin
                    cap_en = any_det;
                end
            end
            default: cap_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= H_ARMED;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_a_q <= '0;
            syn_b_q <= '0;
            line_q  <= '0;
            edc_q   <= 1'b0;
            unc_q   <= 1'b0;
            par_q   <= 1'b0;
            munc_q  <= 1'b0;
            mpar_q  <= 1'b0;
        end else begin
            if (cap_en) begin
                syn_a_q <= syn_a;
                syn_b_q <= syn_b;
                line_q  <= line_in;
                edc_q   <= det_unc;
                unc_q   <= det_unc;
                par_q   <= det_par;
            end else begin
                unc_q   <= unc_q & ~clr[0];
                par_q   <= par_q & ~clr[2];
            end
            munc_q <= (munc_q & ~clr[1]) | set_munc;
            mpar_q <= (mpar_q & ~clr[3]) | set_mpar;
        end
    end

    always_comb begin
        word = '0;
        word[SYN_W-1:0]       = syn_a_q;
        word[O_EDC-1:SYN_W]   = syn_b_q;
        word[O_EDC]           = edc_q;
        word[O_LINE +: 4]     = line_q;
        word[O_FLG]           = unc_q;
        word[O_FLG + 1]       = munc_q;
        word[O_FLG + 2]       = par_q;
        word[O_FLG + 3]       = mpar_q;
    end

    assign frozen = (state_q == H_FROZEN);

endmodule

// File: rtl/cec_ceaddr.sv
module cec_ceaddr
    import cec_pkg::*;
#(
    parameter int IDX_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det_ce,
    input  logic             ce_ptr,
    input  logic             idx_vld,
    input  logic [IDX_W-1:0] map_idx,
    input  logic             clr,
    output logic [IDX_W-1:0] idx,
    output logic             ce_flag,
    output logic             ptr_ok
);
    ce_st_e           state_q, state_d;
    logic             cap_en, track_en;
    logic [IDX_W-1:0] idx_q;
    logic             ptr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_TRACK: if (det_ce) state_d = C_HELD;
            C_HELD:  if (clr && !det_ce) state_d = C_TRACK;
            default: state_d = C_TRACK;
        endcase
    end

    always_comb begin
        cap_en   = 1'b0;
        track_en = 1'b0;
        unique case (state_q)
            C_TRACK: begin
                cap_en   = det_ce;
                track_en = idx_vld;
            end
            C_HELD: begin
                cap_en   = clr & det_ce;
                track_en = clr & idx_vld;
            end
            default: track_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= C_TRACK;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ptr_q <= 1'b0;
        end else begin
            if (track_en) idx_q <= map_idx;
            if (cap_en)   ptr_q <= ce_ptr;
        end
    end

    assign idx     = idx_q;
    assign ce_flag = (state_q == C_HELD);
    assign ptr_ok  = ptr_q;

endmodule

// File: rtl/cec_capture_unit.sv
module cec_capture_unit
    import cec_pkg::*;
#(
    parameter int SYN_W = 8,
    parameter int IDX_W = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         txn_kind,
    input  logic [1:0]         unc_err,
    input  logic [1:0]         par_err,
    input  logic [3:0]         ce_err,
    input  logic               idx_vld,
    input  logic [IDX_W-1:0]   map_idx,
    input  logic               ln_valid,
    input  logic               ln_dirty,
    input  logic               ln_shared,
    input  logic               ln_cpar,
    input  logic [4*SYN_W-1:0] syn_in,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata
);
    localparam int NLW      = 4;
    localparam int NHALF    = NLW / 2;
    localparam int HALF_W   = 32;
    localparam int FLAG_LSB = 2 * SYN_W + 5;
    localparam int CE_FLAG  = HALF_W;

    logic [NHALF-1:0]  det_unc, det_par, half_frozen;
    logic              det_ce, ce_ptr;
    logic [63:0]       wr_mask0;
    logic              ce_clr;
    logic [HALF_W-1:0] half_word [NHALF];
    logic [63:0]       ce_word;
    logic [IDX_W-1:0]  ce_idx;
    logic              ce_flag, ce_ptr_ok;
    line_st_t          line_in;

    assign line_in  = '{cpar: ln_cpar, shared: ln_shared, dirty: ln_dirty, valid: ln_valid};
    assign wr_mask0 = (reg_wr && !reg_sel) ? reg_wdata : 64'd0;
    assign ce_clr   = reg_wr && reg_sel && reg_wdata[CE_FLAG];

    cec_qual #(.NHALF(NHALF), .NLW(NLW)) u_qual (
        .txn_kind (txn_kind),
        .unc_err  (unc_err),
        .par_err  (par_err),
        .ce_err   (ce_err),
        .det_unc  (det_unc),
        .det_par  (det_par),
        .det_ce   (det_ce),
        .ce_ptr   (ce_ptr)
    );

    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            cec_half #(.SYN_W(SYN_W), .WORD_W(HALF_W)) u_half (
                .clk     (clk),
                .rst     (rst),
                .det_unc (det_unc[h]),
                .det_par (det_par[h]),
                .line_in (line_in),
                .syn_a   (syn_in[h*SYN_W +: SYN_W]),
                .syn_b   (syn_in[(h+NHALF)*SYN_W +: SYN_W]),
                .clr     (wr_mask0[h*HALF_W + FLAG_LSB +: 4]),
                .word    (half_word[h]),
                .frozen  (half_frozen[h])
            );
        end
    endgenerate

    cec_ceaddr #(.IDX_W(IDX_W)) u_ce (
        .clk     (clk),
        .rst     (rst),
        .det_ce  (det_ce),
        .ce_ptr  (ce_ptr),
        .idx_vld (idx_vld),
        .map_idx (map_idx),
        .clr     (ce_clr),
        .idx     (ce_idx),
        .ce_flag (ce_flag),
        .ptr_ok  (ce_ptr_ok)
    );

    always_comb begin
        ce_word                 = '0;
        ce_word[IDX_W-1:0]      = ce_idx;
        ce_word[CE_FLAG]        = ce_flag;
        ce_word[CE_FLAG + 1]    = ce_ptr_ok;
    end

    assign reg_rdata = reg_sel ? ce_word : {half_word[1], half_word[0]};

endmodule

// File: rtl/cec_capture_sva.sv
module cec_capture_sva #(
    parameter int SYN_W = 8,
    parameter int IDX_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       txn_kind,
    input logic [1:0]       unc_err,
    input logic [1:0]       par_err,
    input logic [3:0]       ce_err,
    input logic             idx_vld,
    input logic [IDX_W-1:0] map_idx,
    input logic [31:0]      hw0,
    input logic [31:0]      hw1,
    input logic [63:0]      ce_word,
    input logic [63:0]      wr_mask0,
    input logic             ce_clr,
    input logic [1:0]       half_frozen
);
    localparam int UNC  = 2 * SYN_W + 5;
    localparam int PAR  = UNC + 2;
    localparam int SNAP = UNC;

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hw0 == 32'd0 && hw1 == 32'd0 && ce_word == 64'd0));

    p_frozen_state_r4: assert property (@(posedge clk) disable iff (rst)
        half_frozen[0] == (hw0[UNC] | hw0[PAR]));

    p_freeze_lo_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(hw0[UNC] | hw0[PAR]) && !$past(wr_mask0[UNC]) && !$past(wr_mask0[PAR]))
        |-> hw0[SNAP-1:0] == $past(hw0[SNAP-1:0]));

    p_freeze_hi_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(hw1[UNC] | hw1[PAR]) && !$past(wr_mask0[32+UNC]) && !$past(wr_mask0[32+PAR]))
        |-> hw1[SNAP-1:0] == $past(hw1[SNAP-1:0]));

    p_missed_unc_r5: assert property (@(posedge clk) disable iff (rst)
        $past(txn_kind == 4'd5 && unc_err[0] && hw0[UNC] && !wr_mask0[UNC]) |-> hw0[UNC+1]);

    p_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        $past(hw0[UNC] && !wr_mask0[UNC]) |-> hw0[UNC]);

    p_idle_half_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!hw1[UNC] && !hw1[PAR] && !unc_err[1] && !par_err[1])
        |-> hw1[SNAP-1:0] == $past(hw1[SNAP-1:0]));

    p_edc_excluded_r10: assert property (@(posedge clk) disable iff (rst)
        $past((txn_kind == 4'd2 || txn_kind == 4'd7) && !hw0[UNC]) |-> !hw0[UNC]);

    p_ce_track_r11: assert property (@(posedge clk) disable iff (rst)
        $past(!ce_word[32] && idx_vld && ce_err == 4'd0)
        |-> ce_word[IDX_W-1:0] == $past(map_idx));

    p_ce_hold_r12: assert property (@(posedge clk) disable iff (rst)
        $past(ce_word[32] && !ce_clr) |-> (ce_word[32] && $stable(ce_word[IDX_W-1:0])));

endmodule

bind cec_capture_unit cec_capture_sva #(.SYN_W(SYN_W), .IDX_W(IDX_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .txn_kind    (txn_kind),
    .unc_err     (unc_err),
    .par_err     (par_err),
    .ce_err      (ce_err),
    .idx_vld     (idx_vld),
    .map_idx     (map_idx),
    .hw0         (half_word[0]),
    .hw1         (half_word[1]),
    .ce_word     (ce_word),
    .wr_mask0    (wr_mask0),
    .ce_clr      (ce_clr),
    .half_frozen (half_frozen)
);

// File: tb/tb_cec_capture_unit.sv
module tb_cec_capture_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  txn_kind = '0;
    logic [1:0]  unc_err = '0;
    logic [1:0]  par_err = '0;
    logic [3:0]  ce_err = '0;
    logic        idx_vld = 1'b0;
    logic [16:0] map_idx = '0;
    logic        ln_valid = 1'b0, ln_dirty = 1'b0, ln_shared = 1'b0, ln_cpar = 1'b0;
    logic [31:0] syn_in = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cec_capture_unit dut (
        .clk(clk), .rst(rst), .txn_kind(txn_kind), .unc_err(unc_err),
        .par_err(par_err), .ce_err(ce_err), .idx_vld(idx_vld), .map_idx(map_idx),
        .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_shared(ln_shared),
        .ln_cpar(ln_cpar), .syn_in(syn_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic bit exp_par(input int t);
        return (t >= 1 && t <= 8);
    endfunction

    function automatic bit exp_edc(input int t);
        return exp_par(t) && t != 2 && t != 7;
    endfunction

    // half word per R2 layout
    function automatic logic [31:0] hword(input logic [7:0] sa, input logic [7:0] sb,
                                          input bit edc, input logic [3:0] ln,
                                          input bit unc, input bit munc,
                                          input bit par, input bit mpar);
        return 32'(sa) | (32'(sb) << 8) | (32'(edc) << 16) | (32'(ln) << 17)
             | (32'(unc) << 21) | (32'(munc) << 22) | (32'(par) << 23) | (32'(mpar) << 24);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input bit sel, output logic [63:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    // one cycle of stimulus; line = {cpar,shared,dirty,valid}
    task automatic cyc(input logic [3:0] t, input logic [1:0] u, input logic [1:0] p,
                       input logic [3:0] c, input bit iv, input logic [16:0] ix,
                       input logic [3:0] ln, input logic [31:0] sy,
                       input bit wr, input bit sel, input logic [63:0] wd);
        @(negedge clk);
        txn_kind = t; unc_err = u; par_err = p; ce_err = c;
        idx_vld = iv; map_idx = ix; syn_in = sy;
        {ln_cpar, ln_shared, ln_dirty, ln_valid} = ln;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(negedge clk);
        txn_kind = '0; unc_err = '0; par_err = '0; ce_err = '0;
        idx_vld = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr(input bit sel, input logic [63:0] wd);
        cyc(4'd0, 2'b00, 2'b00, 4'd0, 1'b0, '0, 4'd0, '0, 1'b1, sel, wd);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w0, w1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(1'b0, v); chk("R1 error reg after reset", v, 64'd0);
        rd(1'b1, v); chk("R1 index reg after reset", v, 64'd0);

        // R9 / R10 sweep of every transaction code
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < 3; k++) begin
                cyc(4'(t), (k == 1) ? 2'b01 : 2'b00, (k == 0) ? 2'b01 : 2'b00,
                    (k == 2) ? 4'b0010 : 4'b0000, 1'b0, '0, 4'd0, '0, 1'b0, 1'b0, '0);
                if (k == 0) begin
                    rd(1'b0, v); chk("R9 parity qualify", 64'(v[23]), 64'(exp_par(t)));
                end else if (k == 1) begin
                    rd(1'b0, v); chk("R10 uncorrectable qualify", 64'(v[21]), 64'(exp_edc(t)));
                end else begin
                    rd(1'b1, v); chk("R10 correctable qualify", 64'(v[32]), 64'(exp_edc(t)));
                end
                wr(1'b0, '1);
                wr(1'b1, '1);
            end
        end
        rd(1'b0, v); chk("R6 all flags cleared after sweep", v & 64'h01E0_0000_01E0_0000, 64'd0);

        // R2 capture
        cyc(4'd5, 2'b01, 2'b00, 4'd0, 1'b0, '0, 4'b1101, 32'hD4C3B2A1, 1'b0, 1'b0, '0);
        w0 = hword(8'hA1, 8'hC3, 1'b1, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); chk("R2 uncorrectable snapshot", v, {32'd0, w0});

        // R4 frozen, R5 missed
        cyc(4'd5, 2'b01, 2'b00, 4'd0, 1'b0, '0, 4'b0000, 32'h11111111, 1'b0, 1'b0, '0);
        w0 = w0 | (32'd1 << 22);
        rd(1'b0, v); chk("R4 R5 frozen, missed unc", v, {32'd0, w0});
        cyc(4'd1, 2'b00, 2'b01, 4'd0, 1'b0, '0, 4'b0110, 32'h22222222, 1'b0, 1'b0, '0);
        w0 = w0 | (32'd1 << 24);
        rd(1'b0, v); chk("R5 missed parity", v, {32'd0, w0});

        // R6 write zero, then write one to UNC plus read-only bits
        wr(1'b0, 64'd0);
        rd(1'b0, v); chk("R6 zero write no change", v, {32'd0, w0});
        wr(1'b0, 64'h0000_0000_003F_FFFF);
        w0 = w0 & ~(32'd1 << 21);
        rd(1'b0, v); chk("R6 clear unc only", v, {32'd0, w0});

        // R3 + R5: missed bits do not block capture
        cyc(4'd1, 2'b00, 2'b01, 4'd0, 1'b0, '0, 4'b0010, 32'h55667788, 1'b0, 1'b0, '0);
        w0 = hword(8'h88, 8'h66, 1'b0, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b1);
        rd(1'b0, v); chk("R3 R5 parity capture with missed set", v, {32'd0, w0});

        // R7 clear and error together
        cyc(4'd4, 2'b01, 2'b00, 4'd0, 1'b0, '0, 4'b0001, 32'h0A0B0C0D, 1'b1, 1'b0, 64'h0080_0000);
        w0 = hword(8'h0D, 8'h0B, 1'b1, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b1);
        rd(1'b0, v); chk("R7 new error wins", v, {32'd0, w0});

        // R8 independent halves
        cyc(4'd8, 2'b00, 2'b10, 4'd0, 1'b0, '0, 4'b0100, 32'h9A7B5C3E, 1'b0, 1'b0, '0);
        w1 = hword(8'h5C, 8'h9A, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(1'b0, v); chk("R8 upper half capture", v, {w1, w0});
        wr(1'b0, 64'h01E0_0000);
        w0 = w0 & 32'h001F_FFFF;
        rd(1'b0, v); chk("R8 lower clear leaves upper", v, {w1, w0});
        cyc(4'd3, 2'b01, 2'b00, 4'd0, 1'b0, '0, 4'b1000, 32'hEEDDCCBB, 1'b0, 1'b0, '0);
        w0 = hword(8'hBB, 8'hDD, 1'b1, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); chk("R8 lower recapture, upper frozen", v, {w1, w0});

        // R11 tracking
        cyc(4'd0, 2'b00, 2'b00, 4'd0, 1'b1, 17'h1ABCD, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R11 tracks index", v, 64'h1ABCD);
        cyc(4'd0, 2'b00, 2'b00, 4'd0, 1'b1, 17'h00042, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R11 tracks next index", v, 64'h00042);

        // R12 / R13
        cyc(4'd3, 2'b00, 2'b00, 4'b0010, 1'b1, 17'h00111, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R12 R13 capture lw1 no pointer", v, 64'h1_0000_0111);
        cyc(4'd0, 2'b00, 2'b00, 4'd0, 1'b1, 17'h0F0F0, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R12 index frozen", v, 64'h1_0000_0111);
        wr(1'b1, 64'd0);
        rd(1'b1, v); chk("R12 zero write keeps", v, 64'h1_0000_0111);
        wr(1'b1, 64'h1_0000_0000);
        rd(1'b1, v); chk("R12 cleared", v, 64'h0111);
        cyc(4'd0, 2'b00, 2'b00, 4'd0, 1'b1, 17'h0F0F0, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R11 tracking resumes", v, 64'h0F0F0);
        cyc(4'd5, 2'b00, 2'b00, 4'b0100, 1'b1, 17'h12345, 4'd0, '0, 1'b0, 1'b1, '0);
        rd(1'b1, v); chk("R13 lw2 pointer valid", v, 64'h3_0001_2345);
        cyc(4'd6, 2'b00, 2'b00, 4'b0001, 1'b1, 17'h00ABC, 4'd0, '0, 1'b1, 1'b1, 64'h1_0000_0000);
        rd(1'b1, v); chk("R12 clear with error recaptures", v, 64'h3_0000_0ABC);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1'b0, v); chk("R1 error reg after second reset", v, 64'd0);
        rd(1'b1, v); chk("R1 index reg after second reset", v, 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule